// File: doc/BRIEF.md
# Multichannel PWM with Synchronised Compare Update

This block drives sixteen pulse-width modulated outputs from one time base. A prescaler divides the input clock, and a step counter runs from 0 up to a programmable last step before it wraps. Every channel compares the step counter against its own set-edge value and clear-edge value. All registers are reached through a byte-wide register bus with a single write strobe and a combinational read port.

A build-time mask decides which channels hold their compare values in shadow storage. Software writes new edges into a shadowed channel and then writes 1 to the sync register. The new edges move into the active set at the next period boundary. Every shadowed channel therefore switches at the same step 0, so its output never shows a half-updated pair of edges. Unshadowed channels use new edges as soon as the write completes.

Top module: `shadow_pwm`

## Requirements
- R1: After reset all outputs are low, and every register reads 0: prescale 0x00, last step 0x01, enable 0x02 and 0x03, sync 0x04, and the compare registers.
- R2: One period lasts (last_step + 1) × (prescale + 1) clock cycles. The last step is at 0x01 and the prescale is at 0x00.
- R3: An enabled output rises one clock after the step counter equals the set-edge value and falls one clock after it equals the clear-edge value. Its high time is ((clear − set) mod (last_step + 1)) × (prescale + 1) cycles. For channel n the set edge is at 0x10+2n and the clear edge is at 0x11+2n.
- R4: When the set edge and the clear edge of a channel are equal, its output stays low.
- R5: Enable register 0x02 bit n enables channel n for n = 0..7. Enable register 0x03 bit n−8 enables channel n for n = 8..15. A disabled channel outputs low. Clearing its bit drives the output low on the clock after the write is captured.
- R6: For a shadowed channel, a compare write does not change the waveform until a sync update is performed. Reading the compare register returns the value written.
- R7: Writing a value with bit 0 set to register 0x04 sets a pending flag, which reads back as bit 0 of 0x04. The shadow values are copied at the next period wrap, and the flag then clears. Writing 0 has no effect.
- R8: For an unshadowed channel, compare writes take effect without any sync update, and the pending flag stays 0.
- R9: With last step 0xFF, the longest high time is 255 of 256 steps, and the shortest is 1 step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 6 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| pwm_o | output | NUM_CH | Channel outputs |

## Verification
The hardest case to reach is the window between a sync request and the period wrap, while a shadowed channel keeps running on its old edges. The bench uses a long period so that this window is wide. It reads the pending flag in the same cycle the request is captured, measures a full high phase on the old edges before any sync, and then polls the flag until it clears before it measures the new waveform. A sweep over every edge pair on small periods and prescales checks the wrap-around high-time formula arithmetically.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_PRESCALE = 6'h00;
  localparam logic [ADDR_W-1:0] A_LAST     = 6'h01;
  localparam logic [ADDR_W-1:0] A_EN_LO    = 6'h02;
  localparam logic [ADDR_W-1:0] A_SYNC     = 6'h04;
  localparam logic [ADDR_W-1:0] A_CMP_BASE = 6'h10;

  typedef struct packed {
    logic [DATA_W-1:0] rise;
    logic [DATA_W-1:0] fall;
  } edge_pair_t;

  function automatic logic [ADDR_W-1:0] en_addr(input int ch);
    return ADDR_W'(int'(A_EN_LO) + ch / 8);
  endfunction

  function automatic logic [ADDR_W-1:0] cmp_addr(input int ch, input bit is_fall);
    return ADDR_W'(int'(A_CMP_BASE) + 2 * ch + int'(is_fall));
  endfunction
endpackage

// File: rtl/spwm_timebase.sv
module spwm_timebase #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] prescale_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] step_o,
  output logic         tick_o,
  output logic         wrap_o
);
  logic [W-1:0] pre_q, step_q;

  // >= keeps the counters bounded when a limit is lowered mid-count
  assign tick_o = (pre_q >= prescale_i);
  assign wrap_o = tick_o && (step_q >= last_i);
  assign step_o = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      step_q <= '0;
    end else begin
      pre_q <= tick_o ? '0 : pre_q + 1'b1;
      if (wrap_o)      step_q <= '0;
      else if (tick_o) step_q <= step_q + 1'b1;
    end
  end
endmodule

// File: rtl/spwm_regfile.sv
module spwm_regfile
  import spwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       wrap_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [DATA_W-1:0]          prescale_o,
  output logic [DATA_W-1:0]          last_o,
  output logic [NUM_CH-1:0]          en_o,
  output edge_pair_t [NUM_CH-1:0]    cmp_o,
  output logic                       pend_o,
  output logic                       xfer_o
);
  logic [DATA_W-1:0]       pre_q, last_q;
  logic [NUM_CH-1:0]       en_q;
  edge_pair_t [NUM_CH-1:0] cmp_q;
  logic                    pend_q;
  logic                    sync_set;

  assign sync_set = wr_i && (addr_i == A_SYNC) && wdata_i[0];
  assign xfer_o   = pend_q && wrap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      last_q <= '0;
      en_q   <= '0;
      cmp_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_PRESCALE) pre_q  <= wdata_i;
      if (wr_i && addr_i == A_LAST)     last_q <= wdata_i;
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_i && addr_i == en_addr(c))        en_q[c]       <= wdata_i[c % 8];
        if (wr_i && addr_i == cmp_addr(c, 1'b0)) cmp_q[c].rise <= wdata_i;
        if (wr_i && addr_i == cmp_addr(c, 1'b1)) cmp_q[c].fall <= wdata_i;
      end
      if (sync_set)    pend_q <= 1'b1;
      else if (xfer_o) pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_PRESCALE) rdata_o = pre_q;
    if (addr_i == A_LAST)     rdata_o = last_q;
    if (addr_i == A_SYNC)     rdata_o = {{(DATA_W-1){1'b0}}, pend_q};
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == en_addr(c))        rdata_o[c % 8] = en_q[c];
      if (addr_i == cmp_addr(c, 1'b0)) rdata_o = cmp_q[c].rise;
      if (addr_i == cmp_addr(c, 1'b1)) rdata_o = cmp_q[c].fall;
    end
  end

  assign prescale_o = pre_q;
  assign last_o     = last_q;
  assign en_o       = en_q;
  assign cmp_o      = cmp_q;
  assign pend_o     = pend_q;
endmodule

// File: rtl/spwm_channel.sv
module spwm_channel
  import spwm_pkg::*;
#(
  parameter bit SHADOWED = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  edge_pair_t        cmp_i,
  input  logic              xfer_i,
  input  logic [DATA_W-1:0] step_i,
  output edge_pair_t        act_o,
  output logic              pwm_o
);
  edge_pair_t act;
  logic       hit_r, hit_f, out_q;

  if (SHADOWED) begin : g_shadow
    edge_pair_t act_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     act_q <= '0;
      else if (xfer_i) act_q <= cmp_i;
    end
    assign act = act_q;
  end else begin : g_direct
    logic unused_xfer;
    assign unused_xfer = xfer_i;
    assign act = cmp_i;
  end

  assign hit_r = (step_i == act.rise);
  assign hit_f = (step_i == act.fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              out_q <= 1'b0;
    else if (!en_i)           out_q <= 1'b0;
    else if (hit_r && hit_f)  out_q <= 1'b0;
    else if (hit_r)           out_q <= 1'b1;
    else if (hit_f)           out_q <= 1'b0;
  end

  assign act_o = act;
  assign pwm_o = out_q;
endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
  import spwm_pkg::*;
#(
  parameter int unsigned      NUM_CH      = 16,
  parameter logic [NUM_CH-1:0] SHADOW_MASK = 16'hAAAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [5:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  logic [DATA_W-1:0]       prescale_val, period_val, step_cnt;
  logic                    tick, wrap, sync_pend, xfer;
  logic [NUM_CH-1:0]       ch_en;
  edge_pair_t [NUM_CH-1:0] cmp_w, act_w;
  logic [NUM_CH-1:0][DATA_W-1:0] act_rise, act_fall;

  spwm_regfile #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .wrap_i     (wrap),
    .rdata_o,
    .prescale_o (prescale_val),
    .last_o     (period_val),
    .en_o       (ch_en),
    .cmp_o      (cmp_w),
    .pend_o     (sync_pend),
    .xfer_o     (xfer)
  );

  spwm_timebase #(.W(DATA_W)) u_tb (
    .clk_i, .rst_ni,
    .prescale_i (prescale_val),
    .last_i     (period_val),
    .step_o     (step_cnt),
    .tick_o     (tick),
    .wrap_o     (wrap)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    spwm_channel #(.SHADOWED(SHADOW_MASK[c])) u_ch (
      .clk_i, .rst_ni,
      .en_i   (ch_en[c]),
      .cmp_i  (cmp_w[c]),
      .xfer_i (xfer),
      .step_i (step_cnt),
      .act_o  (act_w[c]),
      .pwm_o  (pwm_o[c])
    );
    assign act_rise[c] = act_w[c].rise;
    assign act_fall[c] = act_w[c].fall;
  end
endmodule

// File: rtl/shadow_pwm_checker.sv
module shadow_pwm_checker #(
  parameter int unsigned NUM_CH = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     wr_i,
  input logic [5:0]               addr_i,
  input logic [7:0]               wdata_i,
  input logic [NUM_CH-1:0]        pwm_o,
  input logic [NUM_CH-1:0]        ch_en,
  input logic                     sync_pend,
  input logic                     tick,
  input logic                     wrap,
  input logic [7:0]               step_cnt,
  input logic [7:0]               period_val,
  input logic [NUM_CH-1:0][7:0]   act_rise,
  input logic [NUM_CH-1:0][7:0]   act_fall
);
  logic sync_wr;
  assign sync_wr = wr_i && (addr_i == spwm_pkg::A_SYNC) && wdata_i[0];

  p_step_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && (step_cnt >= period_val) |=> step_cnt == 8'd0);

  p_pend_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_wr |=> sync_pend);

  p_pend_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_pend && !wrap |=> sync_pend);

  p_pend_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_pend && wrap && !sync_wr |=> !sync_pend);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_dis_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_en[c] |=> !pwm_o[c]);

    p_equal_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_en[c] && (act_rise[c] == act_fall[c]) && (step_cnt == act_rise[c])
      |=> !pwm_o[c]);

    p_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_en[c] && (act_rise[c] != act_fall[c]) && (step_cnt == act_rise[c])
      |=> pwm_o[c]);

    p_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_en[c] && (step_cnt == act_fall[c]) |=> !pwm_o[c]);
  end
endmodule

bind shadow_pwm shadow_pwm_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .pwm_o,
  .ch_en, .sync_pend, .tick, .wrap, .step_cnt, .period_val,
  .act_rise, .act_fall
);

// File: tb/shadow_pwm_tb_top.sv
`timescale 1ns/1ps
module shadow_pwm_tb_top;
  localparam int NUM_CH = 16;
  localparam logic [5:0] A_PRE = 6'h00, A_LAST = 6'h01, A_ENL = 6'h02,
                         A_ENH = 6'h03, A_SYNC = 6'h04, A_CMP = 6'h10;

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [NUM_CH-1:0] pwm;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shadow_pwm #(.NUM_CH(NUM_CH), .SHADOW_MASK(16'hAAAA)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: act %0d cycles exp < 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [5:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic set_edges(input int ch, input int r, input int f);
    wreg(6'(int'(A_CMP) + 2*ch), 8'(r));
    wreg(6'(int'(A_CMP) + 2*ch + 1), 8'(f));
  endtask

  task automatic wait_rise(input int ch);
    logic prev;
    int g = 0;
    @(negedge clk); prev = pwm[ch];
    forever begin
      @(negedge clk);
      if (!prev && pwm[ch]) break;
      prev = pwm[ch];
      g++;
      if (g > 3000) break;
    end
  endtask

  task automatic measure(input int ch, output int hi, output int lo);
    int g = 0;
    hi = 0; lo = 0;
    wait_rise(ch);
    if (!pwm[ch]) return;
    hi = 1;
    forever begin
      @(negedge clk);
      if (!pwm[ch]) break;
      hi++; g++;
      if (g > 3000) return;
    end
    lo = 1;
    forever begin
      @(negedge clk);
      if (pwm[ch]) break;
      lo++; g++;
      if (g > 6000) return;
    end
  endtask

  task automatic poll_sync(output int n);
    logic [7:0] d;
    n = 0;
    forever begin
      @(negedge clk);
      rreg(A_SYNC, d);
      if (!d[0] || n > 2000) break;
      n++;
    end
  endtask

  initial begin
    logic [7:0] d;
    int hi, lo, n, highs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 pwm", int'(pwm), 0);
    foreach (d[i]) begin end
    rreg(A_PRE, d);  chk("R1 prescale", d, 0);
    rreg(A_LAST, d); chk("R1 last", d, 0);
    rreg(A_ENL, d);  chk("R1 en_lo", d, 0);
    rreg(A_ENH, d);  chk("R1 en_hi", d, 0);
    rreg(A_SYNC, d); chk("R1 sync", d, 0);
    for (int c = 0; c < NUM_CH; c++) begin
      rreg(6'(int'(A_CMP) + 2*c), d);     chk("R1 rise", d, 0);
      rreg(6'(int'(A_CMP) + 2*c + 1), d); chk("R1 fall", d, 0);
    end

    // R2 R3 R8: sweep of every edge pair on unshadowed channel 0
    wreg(A_ENL, 8'h01);
    for (int s = 0; s <= 2; s++) begin
      for (int p = 1; p <= 4; p++) begin
        for (int r = 0; r <= p; r++) begin
          for (int f = 0; f <= p; f++) begin
            if (r == f) continue;
            wreg(A_PRE, 8'(s));
            wreg(A_LAST, 8'(p));
            set_edges(0, r, f);
            measure(0, hi, lo);
            chk("R3/R8 high time", hi, (((f - r) + (p + 1)) % (p + 1)) * (s + 1));
            chk("R2 period", hi + lo, (p + 1) * (s + 1));
          end
        end
      end
    end
    rreg(A_SYNC, d); chk("R8 no pending", d, 0);

    // R4: equal edges keep the output low
    wreg(A_PRE, 8'd1); wreg(A_LAST, 8'd4);
    set_edges(0, 2, 2);
    repeat (20) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pwm[0]) highs++;
    end
    chk("R4 equal edges high count", highs, 0);

    // R9: last step 0xFF limits
    wreg(A_PRE, 8'd0); wreg(A_LAST, 8'hFF);
    set_edges(0, 0, 255);
    measure(0, hi, lo);
    chk("R9 max high", hi, 255);
    chk("R9 max low", lo, 1);
    set_edges(0, 255, 0);
    measure(0, hi, lo);
    chk("R9 min high", hi, 1);
    chk("R9 min low", lo, 255);

    // R6 R7: shadowed channel 1, period 6 steps x 4 cycles
    wreg(A_ENL, 8'h02);
    wreg(A_PRE, 8'd3); wreg(A_LAST, 8'd5);
    set_edges(1, 0, 2);
    wreg(A_SYNC, 8'h01);
    poll_sync(n);
    chk("R7 transfer done", int'(n <= 30), 1);
    measure(1, hi, lo);
    chk("R7 high after sync", hi, 8);
    chk("R2 shadow period", hi + lo, 24);
    wreg(6'(int'(A_CMP) + 3), 8'd4);
    rreg(6'(int'(A_CMP) + 3), d); chk("R6 readback", d, 4);
    repeat (30) @(negedge clk);
    measure(1, hi, lo);
    chk("R6 high unchanged", hi, 8);
    wreg(A_SYNC, 8'h01);
    rreg(A_SYNC, d); chk("R7 pending set", d, 1);
    poll_sync(n);
    chk("R7 cleared within a period", int'(n <= 30), 1);
    measure(1, hi, lo);
    chk("R7 high after transfer", hi, 16);
    chk("R7 low after transfer", lo, 8);
    wreg(A_SYNC, 8'h00);
    rreg(A_SYNC, d); chk("R7 write 0 ignored", d, 0);

    // R5: upper enable register maps channel 9
    wreg(A_ENL, 8'h00);
    wreg(A_ENH, 8'h02);
    rreg(A_ENH, d); chk("R5 en_hi readback", d, 2);
    set_edges(9, 1, 3);
    wreg(A_SYNC, 8'h01);
    poll_sync(n);
    measure(9, hi, lo);
    chk("R5 ch9 high", hi, 8);
    chk("R5 ch9 period", hi + lo, 24);
    highs = 0;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (pwm[1] || pwm[8]) highs++;
    end
    chk("R5 ch1/ch8 idle", highs, 0);
    wait_rise(9);
    wreg(A_ENH, 8'h00);
    @(negedge clk);
    chk("R5 disable next clock", int'(pwm[9]), 0);
    highs = 0;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (pwm != '0) highs++;
    end
    chk("R5 all disabled low", highs, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule